// File: doc/BRIEF.md
# Dual External Interrupt Sense Controller

This block turns two external interrupt pins into interrupt request lines. Each pin is first brought into the clock domain by a synchronizer. It is then compared with its previous sample, and a per-channel two-bit sense field chooses what counts as a request: a low level, any change, a falling edge or a rising edge. Edge and change events set a sticky pending flag that stays set until an acknowledge or clear pulse. A low level produces a request only while the sampled pin stays low and is never stored.

The two sense fields share one byte-wide control register that is written through a simple write strobe and can be read at all times. The upper nibble is reserved. A channel's request line is driven only when the global interrupt enable and that channel's mask are both high. The pending flag still records events while the channel is masked.

Top module: `ext_irq_sense`

## Requirements
- R1: The control byte is written on a clock edge where `reg_we` is high and reads back on `reg_rdata` from the next cycle. Bits 1:0 are the sense field of channel 0 and bits 3:2 are the sense field of channel 1.
- R2: After reset every control bit reads 0, so both channels are in low-level mode. No pending flag is set and `irq_o` is 0.
- R3: Bits 7:4 of `reg_rdata` always read 0, and writing ones to them changes nothing.
- R4: Sense code 00 (low level): the request follows the sampled pin. It rises on the second clock edge after the pin goes low and falls on the second clock edge after the pin goes high. It is not latched.
- R5: Sense code 01 (any change): every change of the sampled pin sets the pending flag. The request rises on the third clock edge after the pin changes.
- R6: Sense code 10 sets pending on a falling pin only, and code 11 sets it on a rising pin only, with the same three-edge latency. The opposite edge has no effect.
- R7: Pending stays set until `ack_i` or `clr_i` of that channel is high on a clock edge. If a new qualifying edge arrives on the same edge as the clear, pending stays set.
- R8: `irq_o[i]` is high only when `global_en` and `mask_i[i]` are both high. A pending flag set while the channel is masked raises `irq_o[i]` as soon as the mask is set again.
- R9: A pin level held stable across a single rising clock edge (one clock period) is seen, so in an edge mode it produces a request.
- R10: Changing a channel's sense field while its pin is stable does not create a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Data written to the control byte |
| reg_rdata | output | 8 | Current control byte; upper nibble reads 0 |
| pin_i | input | 2 | External interrupt pins, asynchronous |
| global_en | input | 1 | Global interrupt enable |
| mask_i | input | 2 | Per-channel interrupt mask |
| ack_i | input | 2 | Per-channel acknowledge, clears pending |
| clr_i | input | 2 | Per-channel clear (write-one), clears pending |
| irq_o | output | 2 | Per-channel interrupt request |

## Verification
The bench builds the block with its defaults: two channels, a byte-wide register and a two-stage synchronizer. This makes every pairing of the four sense codes across both channels reachable, including one channel in level mode while the other latches edges. Random pin activity, writes to the control byte, mask and enable changes and acknowledge pulses run for several thousand cycles. This puts clears on the same edge as new events and mode changes during pin activity. Directed sequences cover the exact latency of each mode, single-period pulses and mode switches on a quiet pin.

// File: rtl/irq_sense_pkg.sv
// Package: shared types for the external interrupt sense controller.
// Assumes a two-bit sense field per channel.
package irq_sense_pkg;

    localparam int SENSE_W = 2;

    // Sense field encoding; the code values are visible to software.
    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

endpackage

// File: rtl/irq_sense_ctrl_reg.sv
// Module: control byte holding one sense field per channel.
// Assumes REG_W >= NUM_CH*SENSE_W; the bits above the fields are reserved,
// are not stored and read as zero.
module irq_sense_ctrl_reg
    import irq_sense_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int REG_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [REG_W-1:0]                wr_data,
    output logic [REG_W-1:0]                rd_data,
    output logic [NUM_CH-1:0][SENSE_W-1:0]  mode_o
);
    localparam int USED_W = NUM_CH * SENSE_W;
    localparam int RSV_W  = REG_W - USED_W;

    logic [USED_W-1:0] fields_q;
    logic              unused_rsv;

    // Store the sense fields; reserved bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr_en) begin
            fields_q <= wr_data[USED_W-1:0];
        end
    end

    // Read path: fields in the low bits, zeros above.
    generate
        if (RSV_W > 0) begin : g_rsv
            assign rd_data    = {{RSV_W{1'b0}}, fields_q};
            assign unused_rsv = ^wr_data[REG_W-1:USED_W];
        end else begin : g_full
            assign rd_data    = fields_q;
            assign unused_rsv = 1'b0;
        end
    endgenerate

    // Split the packed fields per channel.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_split
            assign mode_o[gi] = fields_q[gi*SENSE_W +: SENSE_W];
        end
    endgenerate

endmodule

// File: rtl/irq_pin_sync.sv
// Module: multi-stage synchronizer for one asynchronous pin, followed by a
// previous-sample register used for edge detection.
// Assumes STAGES >= 2; the pin idles at RST_VAL, which the chain resets to.
module irq_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic cur_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
        end
    end

    // Hold the last synchronized sample; it is not touched by mode changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/irq_edge_detect.sv
// Module: per-channel condition detector with a sticky pending flag.
// Assumes cur_i/prev_i are synchronized samples one cycle apart.
module irq_edge_detect
    import irq_sense_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SENSE_W-1:0] mode_i,
    input  logic               cur_i,
    input  logic               prev_i,
    input  logic               ack_i,
    input  logic               clr_i,
    output logic               pend_o,
    output logic               req_o
);
    sense_e mode;
    logic   rise;
    logic   fall;
    logic   hit;
    logic   level;
    logic   pend_q;

    assign mode = sense_e'(mode_i);
    assign rise = cur_i & ~prev_i;
    assign fall = ~cur_i & prev_i;

    // Decode which sampled event the selected mode reacts to.
    always_comb begin
        hit   = 1'b0;
        level = 1'b0;
        unique case (mode)
            SENSE_LOW:  level = ~cur_i;
            SENSE_ANY:  hit   = rise | fall;
            SENSE_FALL: hit   = fall;
            SENSE_RISE: hit   = rise;
            default:    hit   = 1'b0;
        endcase
    end

    // Sticky pending flag: a new event wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (ack_i || clr_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign req_o  = pend_q | level;

endmodule

// File: rtl/ext_irq_sense.sv
// Module: top of the dual external interrupt sense controller.
// Each channel: synchronizer -> detector; request gated by mask and global
// enable. Assumes synchronous active-low reset and idle-high pins.
module ext_irq_sense
    import irq_sense_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic              global_en,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [NUM_CH-1:0] ack_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_CH-1:0][SENSE_W-1:0] mode;
    logic [NUM_CH-1:0]              cur_s;
    logic [NUM_CH-1:0]              prev_s;
    logic [NUM_CH-1:0]              pend_q;
    logic [NUM_CH-1:0]              req;

    irq_sense_ctrl_reg #(
        .NUM_CH (NUM_CH),
        .REG_W  (REG_W)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .mode_o  (mode)
    );

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            irq_pin_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) sync_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (pin_i[gc]),
                .cur_o  (cur_s[gc]),
                .prev_o (prev_s[gc])
            );

            irq_edge_detect det_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .mode_i (mode[gc]),
                .cur_i  (cur_s[gc]),
                .prev_i (prev_s[gc]),
                .ack_i  (ack_i[gc]),
                .clr_i  (clr_i[gc]),
                .pend_o (pend_q[gc]),
                .req_o  (req[gc])
            );

            // Gate the request with the channel mask and global enable.
            assign irq_o[gc] = req[gc] & mask_i[gc] & global_en;
        end
    endgenerate

endmodule

// File: rtl/irq_sense_chk.sv
// Module: assertion checker bound to ext_irq_sense.
// Assumes it observes the top's ports and the per-channel pending flags.
module irq_sense_chk #(
    parameter int NUM_CH = 2,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              global_en,
    input logic [NUM_CH-1:0] mask_i,
    input logic [NUM_CH-1:0] ack_i,
    input logic [NUM_CH-1:0] clr_i,
    input logic [NUM_CH-1:0] irq_o,
    input logic [NUM_CH-1:0] pend
);
    localparam int USED_W = 2 * NUM_CH;

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_rdata[USED_W-1:0] == $past(reg_wdata[USED_W-1:0])); // R1

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_rdata == '0 && pend == '0)); // R2

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:USED_W] == '0); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~(ack_i | clr_i)) != '0) |=>
        ((pend & $past(pend & ~(ack_i | clr_i))) == $past(pend & ~(ack_i | clr_i)))); // R7

    AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~mask_i) == '0) && (global_en || irq_o == '0)); // R8

endmodule

bind ext_irq_sense irq_sense_chk #(
    .NUM_CH (NUM_CH),
    .REG_W  (REG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .global_en (global_en),
    .mask_i    (mask_i),
    .ack_i     (ack_i),
    .clr_i     (clr_i),
    .irq_o     (irq_o),
    .pend      (pend_q)
);

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random stimulus, checked against
// a reference model written from the requirements.
module ext_irq_sense_tb_top;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] pin_i = '1;
    logic           global_en = 1'b0;
    logic [NCH-1:0] mask_i = '0;
    logic [NCH-1:0] ack_i = '0;
    logic [NCH-1:0] clr_i = '0;
    logic [NCH-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_irq_sense dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_i     (pin_i),
        .global_en (global_en),
        .mask_i    (mask_i),
        .ack_i     (ack_i),
        .clr_i     (clr_i),
        .irq_o     (irq_o)
    );

    // Reference model: two-edge sampling, one more edge for pending.
    logic [3:0]     m_ctrl;
    logic [NCH-1:0] m_s1, m_s2, m_prev, m_pend;

    function automatic logic m_hit(input logic [1:0] md, input logic c, input logic p);
        case (md)
            2'b01:   return c != p;
            2'b10:   return !c && p;
            2'b11:   return c && !p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [NCH-1:0] m_irq();
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            r[i] = (m_pend[i] | (m_ctrl[2*i +: 2] == 2'b00 && !m_s2[i]))
                   & mask_i[i] & global_en;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl <= '0; m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_pend <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (m_hit(m_ctrl[2*i +: 2], m_s2[i], m_prev[i])) m_pend[i] <= 1'b1;
                else if (ack_i[i] || clr_i[i])                   m_pend[i] <= 1'b0;
            end
            if (reg_we) m_ctrl <= reg_wdata[3:0];
            m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one cycle; compare against the model at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        ack_i  = '0;
        clr_i  = '0;
        chk("MODEL irq", irq_o, m_irq());
        chk("MODEL rdata", reg_rdata, {4'h0, m_ctrl});
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v;
        step();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R2 reset ctrl", reg_rdata, 8'h00);
        chk("R2 reset irq", irq_o, 2'b00);
        global_en = 1'b1; mask_i = 2'b11;
        step();
        chk("R2 idle high pins no irq", irq_o, 2'b00);

        // R3: reserved bits.
        wr(8'hFF);
        chk("R3 reserved read zero", reg_rdata, 8'h0F);
        wr(8'hF0);
        chk("R3 reserved write ignored", reg_rdata, 8'h00);

        // R4: low level follows the pin, two-edge latency, not latched.
        pin_i[0] = 1'b0;
        step(); chk("R4 low after 1 edge", irq_o[0], 1'b0);
        step(); chk("R4 low after 2 edges", irq_o[0], 1'b1);
        pin_i[0] = 1'b1;
        step(); chk("R4 high after 1 edge", irq_o[0], 1'b1);
        step(); chk("R4 not latched", irq_o[0], 1'b0);

        // R6: rising mode ignores falling, catches rising.
        wr(8'h03);
        chk("R1 field ch0", reg_rdata, 8'h03);
        pin_i[0] = 1'b0;
        steps(4); chk("R6 falling ignored in rise mode", irq_o[0], 1'b0);
        pin_i[0] = 1'b1;
        steps(2); chk("R6 rise latency 2", irq_o[0], 1'b0);
        step();   chk("R6 rise latency 3", irq_o[0], 1'b1);
        steps(3); chk("R7 pending sticky", irq_o[0], 1'b1);
        ack_i[0] = 1'b1;
        step();   chk("R7 ack clears", irq_o[0], 1'b0);

        // R10: mode change on quiet pin makes no request.
        wr(8'h02); steps(3);
        chk("R10 switch to fall", irq_o[0], 1'b0);
        wr(8'h01); steps(3);
        chk("R10 switch to any", irq_o[0], 1'b0);

        // R9: one-period pulse in fall mode.
        wr(8'h02);
        pin_i[0] = 1'b0; step();
        pin_i[0] = 1'b1; steps(3);
        chk("R9 single period pulse", irq_o[0], 1'b1);
        clr_i[0] = 1'b1; step();
        chk("R7 clr clears", irq_o[0], 1'b0);

        // R8: masked event retained.
        mask_i[0] = 1'b0;
        pin_i[0] = 1'b0; steps(4);
        chk("R8 masked no irq", irq_o[0], 1'b0);
        mask_i[0] = 1'b1; #1;
        chk("R8 unmask shows pending", irq_o[0], 1'b1);
        global_en = 1'b0; #1;
        chk("R8 global disable", irq_o[0], 1'b0);
        global_en = 1'b1; pin_i[0] = 1'b1;
        clr_i[0] = 1'b1; step();

        // R5: any-change mode on channel 1.
        wr(8'h04);
        chk("R1 field ch1", reg_rdata, 8'h04);
        pin_i[1] = 1'b0; steps(3);
        chk("R5 fall in any mode", irq_o[1], 1'b1);
        ack_i[1] = 1'b1; step();
        chk("R5 ack", irq_o[1], 1'b0);
        pin_i[1] = 1'b1; steps(3);
        chk("R5 rise in any mode", irq_o[1], 1'b1);
        ack_i[1] = 1'b1; step();

        // Random phase: compared against the model each cycle (R1-R10 paths).
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0) begin
                reg_we = 1'b1; reg_wdata = 8'($urandom);
            end
            if ($urandom_range(0, 3) == 0) pin_i = NCH'($urandom);
            if ($urandom_range(0, 7) == 0) ack_i = NCH'($urandom);
            if ($urandom_range(0, 7) == 0) clr_i = NCH'($urandom);
            if ($urandom_range(0, 31) == 0) mask_i = NCH'($urandom);
            if ($urandom_range(0, 63) == 0) global_en = ~global_en;
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule